// File: doc/BRIEF.md
# Line-Sync Regenerator with Jitter Rejection

This block sits in the pixel-clock domain of a digital video receiver, after the sync and data-enable signals have been recovered. Some sources let the horizontal sync wander by one pixel in either direction from line to line. If that wander reaches the display timing controller, it loses its line timing. The block treats the falling edge of data enable as the only timing reference. It runs a pixel counter from that edge and measures where each sync pulse starts and how long it lasts. From those measurements it rebuilds a sync pulse that sits on an 8-pixel grid and holds still while the source jitters.

Data enable, the pixel word and the sync lines all pass through the same fixed pipeline, so data enable keeps its exact place relative to the pixels. After reset, the block passes the received sync through unchanged. Once two consecutive lines agree within one pixel, it switches to the regenerated timing and raises a lock flag. A larger change in the incoming timing drops it back to pass-through until the new timing repeats. The vertical sync is resampled onto the regenerated line edge so that the phase between frame and line stays constant. A configuration pin selects the sync polarity.

Top module: `hsync_regen`

## Requirements
- R1: `de_o` and `data_o` equal `de_i` and `data_i` delayed by exactly `DELAY` clocks (`DELAY` is at least 8, default 12).
- R2: Position 0 is the first clock with `de_i` low after a clock with it high. Each later clock adds 1. A sync leading edge is recorded as the position of the first active clock. Sync pulses seen before the first DE fall after reset are not measured.
- R3: Until lock, `hs_o` and `vs_o` are the received sync delayed by `DELAY`, and `locked_o` is low.
- R4: A measurement whose start and width each lie within one pixel of the stored reference sets lock. Regenerated output begins on the clock after the next DE fall. `locked_o` is high while regenerated output is selected, aligned with the delayed stream.
- R5: A measurement within one pixel in start and width leaves the stored reference unchanged, so the regenerated pulse does not move.
- R6: The regenerated pulse starts at the stored start rounded to a multiple of 8: a remainder of 0 to 3 rounds down and 4 to 7 rounds up.
- R7: The regenerated pulse width is the stored width rounded the same way, with a minimum of 8 pixels.
- R8: A measurement that differs by more than one pixel replaces the reference. It clears lock and returns to pass-through from the next clock. Lock returns only after another agreeing line.
- R9: While regenerating, `vs_o` changes state only on the clock where the regenerated sync pulse starts, taking the received vertical sync level at that clock.
- R10: With `hs_pol_i` = 1 the sync is active high at input and output. With 0 it is active low at both.
- R11: During reset the outputs are: `de_o`, `data_o`, `vs_o` and `locked_o` all 0, and `hs_o` inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_pol_i | input | 1 | Sync polarity: 1 active high, 0 active low |
| de_i | input | 1 | Received data enable |
| hs_i | input | 1 | Received horizontal sync |
| vs_i | input | 1 | Received vertical sync |
| data_i | input | DATA_W | Received pixel word |
| de_o | output | 1 | Delayed data enable |
| hs_o | output | 1 | Regenerated or passed horizontal sync |
| vs_o | output | 1 | Resampled or passed vertical sync |
| data_o | output | DATA_W | Delayed pixel word |
| locked_o | output | 1 | Regenerated timing in use |

## Verification
The hardest state to reach is a loss of lock while a regenerated pulse is already on the output. The change must also happen in the same line in which the reference is rewritten. The stimulus reaches it by driving a stable, jittering run until lock, then moving the sync start by 16 pixels. It follows with a width change small enough that the new raw pulse overlaps the old grid window. A behavioural model in the bench tracks every output on every clock. Per-line offsets measured from the delayed DE fall are compared against values worked out by hand from the rounding rules.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  localparam int unsigned GRID_LG = 3;

  typedef struct packed {
    logic lock;
    logic vs;
    logic hs;
    logic de;
  } side_t;
endpackage

// File: rtl/hsr_delay.sv
module hsr_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= d_i;
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[DEPTH-1];
endmodule

// File: rtl/hsr_meas.sv
module hsr_meas #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             de_i,
  input  logic             hs_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W-1:0] len_o,
  output logic             de_fall_o,
  output logic             locked_o,
  output logic             drop_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic de_q, hs_q, started_q, armed_q, have_q, locked_q;
  logic [CNT_W-1:0] cnt_q, start_q, pos_q, len_q;
  logic [CNT_W-1:0] cnt_d, width, dpos, dlen;
  logic hs_rise, hs_fall, done, match;

  assign de_fall_o = de_q & ~de_i;
  assign cnt_d     = de_fall_o ? '0 : ((cnt_q == CNT_MAX) ? cnt_q : cnt_q + ONE);
  assign hs_rise   = hs_i & ~hs_q;
  assign hs_fall   = ~hs_i & hs_q;
  assign done      = hs_fall & armed_q;
  assign width     = cnt_d - start_q;
  assign dpos      = (start_q >= pos_q) ? start_q - pos_q : pos_q - start_q;
  assign dlen      = (width >= len_q) ? width - len_q : len_q - width;
  assign match     = have_q && (dpos <= ONE) && (dlen <= ONE);
  assign drop_o    = done & ~match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q      <= 1'b0;
      hs_q      <= 1'b0;
      cnt_q     <= '0;
      started_q <= 1'b0;
      armed_q   <= 1'b0;
      have_q    <= 1'b0;
      locked_q  <= 1'b0;
      start_q   <= '0;
      pos_q     <= '0;
      len_q     <= '0;
    end else begin
      de_q      <= de_i;
      hs_q      <= hs_i;
      cnt_q     <= cnt_d;
      started_q <= started_q | de_fall_o;
      if (hs_rise && (started_q || de_fall_o)) begin
        armed_q <= 1'b1;
        start_q <= cnt_d;
      end else if (done) begin
        armed_q <= 1'b0;
        if (match) begin
          locked_q <= 1'b1;
        end else begin
          pos_q    <= start_q;
          len_q    <= width;
          have_q   <= 1'b1;
          locked_q <= 1'b0;
        end
      end
    end
  end

  assign cnt_o    = cnt_d;
  assign pos_o    = pos_q;
  assign len_o    = len_q;
  assign locked_o = locked_q;

  a_r2_count_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_fall_o |=> (cnt_q == '0));

  a_r5_ref_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && match) |=> ($stable(pos_q) && $stable(len_q) && locked_q));

  a_r8_ref_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> !locked_q);
endmodule

// File: rtl/hsr_gen.sv
module hsr_gen #(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned GRID_LG = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             de_fall_i,
  input  logic             locked_i,
  input  logic             drop_i,
  input  logic [CNT_W-1:0] pos_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             hs_raw_i,
  input  logic             vs_raw_i,
  output logic             hs_sel_o,
  output logic             vs_sel_o,
  output logic             regen_o
);
  localparam int unsigned EW   = CNT_W + 2;
  localparam int unsigned HALF = 1 << (GRID_LG - 1);
  localparam logic [EW-1:0] GRID_LEN = EW'(1 << GRID_LG);

  function automatic logic [EW-1:0] grid_round(input logic [CNT_W-1:0] v);
    logic [EW-1:0] t;
    t = EW'(v) + EW'(HALF);
    t[GRID_LG-1:0] = '0;
    return t;
  endfunction

  logic regen_q, gen_q, vs_hold_q;
  logic [EW-1:0] len_r, len_g, win_lo, win_hi, cnt_e;
  logic gen, gen_rise;

  assign len_r    = grid_round(len_i);
  assign len_g    = (len_r == '0) ? GRID_LEN : len_r;
  assign win_lo   = grid_round(pos_i);
  assign win_hi   = win_lo + len_g;
  assign cnt_e    = EW'(cnt_i);
  assign gen      = regen_q && (cnt_e >= win_lo) && (cnt_e < win_hi);
  assign gen_rise = gen & ~gen_q;

  assign hs_sel_o = regen_q ? gen : hs_raw_i;
  assign vs_sel_o = regen_q ? (gen_rise ? vs_raw_i : vs_hold_q) : vs_raw_i;
  assign regen_o  = regen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regen_q   <= 1'b0;
      gen_q     <= 1'b0;
      vs_hold_q <= 1'b0;
    end else begin
      if (drop_i)                      regen_q <= 1'b0;
      else if (de_fall_i && locked_i)  regen_q <= 1'b1;
      gen_q     <= gen;
      vs_hold_q <= vs_sel_o;
    end
  end

  a_r4_lock_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(regen_q) |-> $past(locked_i));

  a_r8_drop_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |=> !regen_q);

  a_r6_on_grid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_rise && $past(regen_q)) |-> (cnt_i[GRID_LG-1:0] == '0));

  a_r9_vs_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regen_q && $past(regen_q) && (vs_sel_o != $past(vs_sel_o))) |-> gen_rise);
endmodule

// File: rtl/hsync_regen.sv
module hsync_regen
  import hsr_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned DELAY  = 12,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_pol_i,
  input  logic              de_i,
  input  logic              hs_i,
  input  logic              vs_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              de_o,
  output logic              hs_o,
  output logic              vs_o,
  output logic [DATA_W-1:0] data_o,
  output logic              locked_o
);
  localparam int unsigned SIDE_W = $bits(side_t);
  localparam int unsigned PIPE_W = DATA_W + SIDE_W;

  logic hs_act, de_fall, locked, drop, hs_sel, vs_sel, regen;
  logic [CNT_W-1:0] cnt, ref_pos, ref_len;
  side_t side_in, side_out;
  logic [PIPE_W-1:0] pipe_in, pipe_out;

  assign hs_act = hs_pol_i ? hs_i : ~hs_i;

  hsr_meas #(.CNT_W(CNT_W)) i_meas (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .de_i      (de_i),
    .hs_i      (hs_act),
    .cnt_o     (cnt),
    .pos_o     (ref_pos),
    .len_o     (ref_len),
    .de_fall_o (de_fall),
    .locked_o  (locked),
    .drop_o    (drop)
  );

  hsr_gen #(.CNT_W(CNT_W), .GRID_LG(GRID_LG)) i_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt),
    .de_fall_i (de_fall),
    .locked_i  (locked),
    .drop_i    (drop),
    .pos_i     (ref_pos),
    .len_i     (ref_len),
    .hs_raw_i  (hs_act),
    .vs_raw_i  (vs_i),
    .hs_sel_o  (hs_sel),
    .vs_sel_o  (vs_sel),
    .regen_o   (regen)
  );

  always_comb begin
    side_in.lock = regen;
    side_in.vs   = vs_sel;
    side_in.hs   = hs_sel;
    side_in.de   = de_i;
  end

  assign pipe_in = {side_in, data_i};

  hsr_delay #(.W(PIPE_W), .DEPTH(DELAY)) i_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pipe_in),
    .q_o    (pipe_out)
  );

  assign side_out = side_t'(pipe_out[PIPE_W-1:DATA_W]);
  assign data_o   = pipe_out[DATA_W-1:0];
  assign de_o     = side_out.de;
  assign vs_o     = side_out.vs;
  assign locked_o = side_out.lock;
  assign hs_o     = hs_pol_i ? side_out.hs : ~side_out.hs;
endmodule

// File: tb/test_hsync_regen.sv
module test_hsync_regen;
  localparam int DW = 24;
  localparam int D  = 12;
  localparam int ACT = 64;
  localparam int BLK = 80;
  localparam int CMAX = 4095;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol = 1'b1;
  logic b_de = 1'b0, b_hs = 1'b0, b_vs = 1'b0;
  logic [DW-1:0] b_data = '0;
  logic de_o, hs_o, vs_o, locked_o;
  logic [DW-1:0] data_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hsync_regen i_hsync_regen (
    .clk_i(clk), .rst_ni(rst_n), .hs_pol_i(pol), .de_i(b_de), .hs_i(b_hs),
    .vs_i(b_vs), .data_i(b_data), .de_o(de_o), .hs_o(hs_o), .vs_o(vs_o),
    .data_o(data_o), .locked_o(locked_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [DW+3:0] q[$];
  int m_cnt, m_pstart, m_pref, m_wref;
  bit m_de_q, m_hq, m_started, m_armed, m_have, m_lock, m_regen, m_gq, m_vh;

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int snap8(input int v);
    return ((v + 4) / 8) * 8;
  endfunction

  task automatic model_reset();
    q.delete();
    m_cnt = 0; m_pstart = 0; m_pref = 0; m_wref = 0;
    m_de_q = 0; m_hq = 0; m_started = 0; m_armed = 0; m_have = 0;
    m_lock = 0; m_regen = 0; m_gq = 0; m_vh = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit ha, fall, st, rise, hfall, g, grise, vsel, hsel, ok, drop;
      int c, gp, gl, w;
      ha    = pol ? b_hs : !b_hs;
      fall  = m_de_q && !b_de;
      c     = fall ? 0 : ((m_cnt == CMAX) ? CMAX : m_cnt + 1);
      st    = m_started || fall;
      rise  = ha && !m_hq;
      hfall = !ha && m_hq;
      gp    = snap8(m_pref);
      gl    = snap8(m_wref);
      if (gl == 0) gl = 8;
      g     = m_regen && (c >= gp) && (c < gp + gl);
      grise = g && !m_gq;
      vsel  = m_regen ? (grise ? b_vs : m_vh) : b_vs;
      hsel  = m_regen ? g : ha;
      q.push_back({m_regen, vsel, hsel, b_de, b_data});
      if (q.size() > D) void'(q.pop_front());
      drop = 0;
      if (rise && st) begin
        m_armed = 1; m_pstart = c;
      end else if (hfall && m_armed) begin
        w = (c - m_pstart) & CMAX;
        ok = m_have && iabs(m_pstart - m_pref) <= 1 && iabs(w - m_wref) <= 1;
        m_armed = 0;
        if (ok) m_lock_next(1);
        else begin
          drop = 1;
          m_pref = m_pstart; m_wref = w; m_have = 1;
        end
      end
      if (drop) m_regen = 0;
      else if (fall && m_lock) m_regen = 1;
      if (drop) m_lock = 0;
      else if (pend_lock) m_lock = 1;
      pend_lock = 0;
      m_cnt = c; m_started = st; m_de_q = b_de; m_hq = ha; m_gq = g; m_vh = vsel;
    end
  end

  bit pend_lock = 0;
  task automatic m_lock_next(input bit v);
    pend_lock = v;
  endtask

  // per-line recorder on the outputs
  int off_a[16], len_a[16], lk_a[16], vs_a[16];
  int line_n, k;
  bit p_de, p_act, p_vs;

  task automatic rec_reset();
    for (int i = 0; i < 16; i++) begin
      off_a[i] = -1; len_a[i] = -1; lk_a[i] = -1; vs_a[i] = -1;
    end
    line_n = -1; k = 0; p_de = 0; p_act = 0; p_vs = 0;
  endtask

  always @(negedge clk) begin
    logic [DW+3:0] e;
    bit act;
    e = (q.size() == D) ? q[0] : '0;
    chk("R1 de_o", int'(de_o), int'(e[DW]));
    chk("R1 data_o", int'(data_o), int'(e[DW-1:0]));
    chk("R4 hs_o", int'(hs_o), int'(pol ? e[DW+1] : !e[DW+1]));
    chk("R9 vs_o", int'(vs_o), int'(e[DW+2]));
    chk("R4 locked_o", int'(locked_o), int'(e[DW+3]));
    if (rst_n) begin
      act = pol ? hs_o : !hs_o;
      if (p_de && !de_o) begin line_n++; k = 0; end
      else k++;
      if (line_n >= 0 && line_n < 16) begin
        if (act && !p_act) begin off_a[line_n] = k; len_a[line_n] = 0; end
        if (act) len_a[line_n]++;
        if (k == 4) lk_a[line_n] = int'(locked_o);
        if (vs_o != p_vs) vs_a[line_n] = k;
      end
      p_de = de_o; p_act = act; p_vs = vs_o;
    end
  end

  // stimulus
  task automatic put(input bit de, input bit act, input bit vs);
    @(posedge clk); #5;
    b_de = de; b_hs = pol ? act : !act; b_vs = vs;
    b_data = b_data + 1'b1;
  endtask

  task automatic idle(input int n, input int ps, input int pw);
    for (int i = 0; i < n; i++) put(1'b0, (i >= ps && i < ps + pw), b_vs);
  endtask

  task automatic line(input int p, input int w, input int vs_at, input bit vs_val);
    for (int i = 0; i < ACT; i++) put(1'b1, 1'b0, b_vs);
    for (int i = 0; i < BLK; i++)
      put(1'b0, (i >= p && i < p + w), (i == vs_at) ? vs_val : b_vs);
  endtask

  task automatic do_reset();
    @(posedge clk); #5;
    rst_n = 0; b_de = 0; b_hs = !pol; b_vs = 0;
    model_reset();
    rec_reset();
    repeat (3) @(posedge clk);
    #10;
    chk("R11 reset de_o", int'(de_o), 0);
    chk("R11 reset data_o", int'(data_o), 0);
    chk("R11 reset vs_o", int'(vs_o), 0);
    chk("R11 reset locked_o", int'(locked_o), 0);
    chk("R11 reset hs_o inactive", int'(hs_o), int'(!pol));
    @(posedge clk); #5;
    rst_n = 1;
  endtask

  initial begin
    model_reset();
    rec_reset();
    pol = 1'b1;
    do_reset();
    idle(20, 5, 4);                 // pulse before any DE fall (R2)
    line(21, 11, -1, 0);            // 0 store
    line(22, 11, 10, 1);            // 1 agree -> lock, raw vs change
    line(20, 11, -1, 0);            // 2 regen
    line(21, 11, 10, 0);            // 3
    line(22, 11, 5, 1);             // 4
    line(37, 11, -1, 0);            // 5 big move -> drop
    line(37, 11, -1, 0);            // 6 agree
    line(38, 11, -1, 0);            // 7 regen at 40
    line(43, 3, -1, 0);             // 8 move -> drop
    line(43, 3, -1, 0);             // 9 agree
    line(44, 3, -1, 0);             // 10 regen at 40, width 8
    line(42, 3, -1, 0);             // 11
    idle(D + 10, 1000, 0);

    chk("R2 raw offset line0", off_a[0], 21);
    chk("R3 unlocked line0", lk_a[0], 0);
    chk("R3 unlocked line1", lk_a[1], 0);
    chk("R3 raw offset line1", off_a[1], 22);
    chk("R3 raw width line1", len_a[1], 11);
    chk("R3 raw vs offset line1", vs_a[1], 10);
    chk("R4 locked line2", lk_a[2], 1);
    chk("R5 offset line2", off_a[2], 24);
    chk("R5 offset line3", off_a[3], 24);
    chk("R5 offset line4", off_a[4], 24);
    chk("R5 width line4", len_a[4], 8);
    chk("R8 still locked line5", lk_a[5], 1);
    chk("R8 unlocked line6", lk_a[6], 0);
    chk("R8 raw offset line6", off_a[6], 37);
    chk("R8 raw width line6", len_a[6], 11);
    chk("R8 relocked line7", lk_a[7], 1);
    chk("R6 round up line7", off_a[7], 40);
    chk("R6 round down line10", off_a[10], 40);
    chk("R6 round down line11", off_a[11], 40);
    chk("R7 min width line10", len_a[10], 8);
    chk("R9 vs at edge line3", vs_a[3], 24);
    chk("R9 vs at edge line4", vs_a[4], 24);

    pol = 1'b0;
    do_reset();
    idle(10, 1000, 0);
    line(21, 11, -1, 0);
    line(22, 11, -1, 0);
    line(21, 11, -1, 0);
    idle(D + 10, 1000, 0);
    chk("R10 low raw offset", off_a[0], 21);
    chk("R10 low raw width", len_a[0], 11);
    chk("R10 low locked", lk_a[2], 1);
    chk("R10 low regen offset", off_a[2], 24);
    chk("R10 low regen width", len_a[2], 8);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule